// File: doc/BRIEF.md
# Process-tagged fully associative address translation buffer

This block keeps a small set of recently used page-table entries and uses them to turn a virtual address into a physical one. Each slot holds a virtual page number, the owning process identifier, a physical frame number and three flags: entry-valid (the cached page-table entry is usable), writable and dirty. A lookup compares the page number and the current process identifier against every slot at once. One cycle later it reports exactly one of four outcomes: hit with physical address, miss, page fault, or protection fault. Pages are 4 KiB, so the low 12 address bits pass through untranslated.

A miss is only reported. An outside walker fetches the entry and writes it through the refill port. A refill either overwrites a slot that already holds the same page and process, or goes into a reserved system slot that the caller chooses, or goes into a slot taken from a free-running replacement counter that never points into the reserved region. Two maintenance inputs drop every slot, or only the slots of one process identifier. The first suits a context switch; the second lets a recycled identifier start clean. The block never writes anything back except the dirty bit. When a write hits a clean, writable entry, the block sets the dirty bit and announces the page on a dirty-update output.

The response path is a small outcome state machine. It has five states: `OUT_IDLE`, `OUT_HIT`, `OUT_MISS`, `OUT_PFAULT` and `OUT_PROT`. Every clock edge moves it according to the lookup presented in that cycle:
- no lookup: to `OUT_IDLE`;
- no tag match: to `OUT_MISS`;
- match whose entry-valid flag is clear: to `OUT_PFAULT`;
- write to a match that is not writable: to `OUT_PROT`;
- otherwise: to `OUT_HIT`.

Any state can reach any other in one edge. The output process decodes the state.

Top module: `tlb_pid_xlate`

## Requirements
- R1: After reset no slot is occupied, `rsp_valid` and `dirty_upd_valid` are low, and the first lookup reports a miss.
- R2: A lookup presented in cycle N gives a response in cycle N+1 with exactly one of hit, miss, page fault or protection fault set. On a hit, `rsp_paddr` is the frame number (bits 31:12) followed by lookup address bits 11:0.
- R3: A hit needs both the page number (address bits 31:12) and `cur_pid` to equal a slot's stored values; a slot of another process gives a miss.
- R4: A tag match on a slot whose entry-valid flag is clear reports a page fault, and `rsp_paddr` is zero for every outcome other than a hit.
- R5: A write lookup that matches a valid slot without write permission reports a protection fault and no dirty update; a read of that slot is a hit.
- R6: A write hit on a clean writable slot sets its dirty bit and raises `dirty_upd_valid` with the page number and process identifier in the response cycle; a later write hit on that slot raises no update.
- R7: `flush_all` empties every slot, the reserved ones included.
- R8: `inv_pid_valid` empties only the slots whose process identifier equals `inv_pid`.
- R9: A refill whose page number and process identifier equal an occupied slot overwrites that slot, so a lookup returns the new frame and flags.
- R10: A refill with `fill_system` high writes reserved slot `fill_slot` (0 to 7); ordinary refills take slots 8 to 63 only, so any number of them never evicts a reserved slot.
- R11: A lookup sees the slot contents from before any refill, flush or invalidation presented in the same cycle. Its dirty update is still reported, and the invalidation still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_pid | input | 6 | Process identifier of the requester |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot matched |
| rsp_page_fault | output | 1 | Matched slot has its entry-valid flag clear |
| rsp_prot_fault | output | 1 | Write to a non-writable entry |
| rsp_paddr | output | 32 | Physical address on hit, zero otherwise |
| fill_valid | input | 1 | Refill request |
| fill_system | input | 1 | Refill goes to a reserved slot |
| fill_slot | input | 3 | Reserved slot index for a system refill |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pid | input | 6 | Process identifier of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| fill_pte_valid | input | 1 | Entry-valid flag of the refill |
| fill_writable | input | 1 | Write permission of the refill |
| fill_dirty | input | 1 | Dirty flag of the refill |
| flush_all | input | 1 | Empty every slot |
| inv_pid_valid | input | 1 | Empty the slots of one process |
| inv_pid | input | 6 | Process identifier to invalidate |
| dirty_upd_valid | output | 1 | A dirty bit was set by the last lookup |
| dirty_upd_vpn | output | 20 | Page number whose dirty bit was set |
| dirty_upd_pid | output | 6 | Process identifier of that page |

## Verification
The bench drives lookups in the same cycle as maintenance and refill, which is where the design can fail.

In one case, a write lookup to a clean page arrives together with invalidation of that page's process. The expected response is a hit with a dirty update, because the lookup sees the old contents. The next lookup of that page must miss, which shows the invalidation was not lost to the dirty-bit write.

In the other case, a lookup of a missing page arrives with the refill for that same page. It must miss, and the following lookup must hit.

// File: rtl/tlb_pid_pkg.sv
package tlb_pid_pkg;
    typedef enum logic [2:0] {
        OUT_IDLE,
        OUT_HIT,
        OUT_MISS,
        OUT_PFAULT,
        OUT_PROT
    } outcome_e;

    typedef struct packed {
        logic pte_ok;
        logic wr_ok;
        logic dirty;
    } pte_flags_t;
endpackage

// File: rtl/tlb_pid_entries.sv
module tlb_pid_entries
    import tlb_pid_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VPN_W     = 20,
    parameter int PID_W     = 6,
    parameter int PFN_W     = 20,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [PID_W-1:0]     lk_pid,
    output logic [N_ENTRIES-1:0] lk_match,
    output logic [PFN_W-1:0]     lk_pfn,
    output pte_flags_t           lk_flags,
    input  logic [VPN_W-1:0]     fl_vpn,
    input  logic [PID_W-1:0]     fl_pid,
    output logic [N_ENTRIES-1:0] fl_match,
    input  logic                 fill_we,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  pte_flags_t           fill_flags,
    input  logic                 dset_we,
    input  logic [IDX_W-1:0]     dset_idx,
    input  logic                 flush_all,
    input  logic                 inv_en,
    input  logic [PID_W-1:0]     inv_pid
);
    logic [N_ENTRIES-1:0] present_q;
    logic [VPN_W-1:0]     vpn_q   [N_ENTRIES];
    logic [PID_W-1:0]     pid_q   [N_ENTRIES];
    logic [PFN_W-1:0]     pfn_q   [N_ENTRIES];
    pte_flags_t           flags_q [N_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                logic             hit_fill;
                logic [PID_W-1:0] eff_pid;
                hit_fill = fill_we && (fill_idx == IDX_W'(i));
                eff_pid  = hit_fill ? fl_pid : pid_q[i];
                if (dset_we && (dset_idx == IDX_W'(i)))
                    flags_q[i].dirty <= 1'b1;
                if (hit_fill) begin
                    vpn_q[i]     <= fl_vpn;
                    pid_q[i]     <= fl_pid;
                    pfn_q[i]     <= fill_pfn;
                    flags_q[i]   <= fill_flags;
                    present_q[i] <= 1'b1;
                end
                // invalidation is applied last so it wins over fill and dirty set
                if (flush_all || (inv_en && (eff_pid == inv_pid)))
                    present_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        lk_pfn   = '0;
        lk_flags = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            lk_match[i] = present_q[i] && (vpn_q[i] == lk_vpn) && (pid_q[i] == lk_pid);
            fl_match[i] = present_q[i] && (vpn_q[i] == fl_vpn) && (pid_q[i] == fl_pid);
            if (lk_match[i]) begin
                lk_pfn   = lk_pfn | pfn_q[i];
                lk_flags = lk_flags | flags_q[i];
            end
        end
    end

    // R9: refill deduplication keeps at most one slot per tag
    assert_unique_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R7: flush empties the whole array
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (present_q == '0));

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_inv_chk
            // R8: no slot of the invalidated process survives
            assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
                inv_en |=> (!present_q[g] || (pid_q[g] != $past(inv_pid))));
        end
    endgenerate
endmodule

// File: rtl/tlb_pid_enc.sv
module tlb_pid_enc #(
    parameter int N_ENTRIES = 64,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] vec,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_ENTRIES; i++)
            if (vec[i]) idx = idx | IDX_W'(i);
        any = |vec;
    end
endmodule

// File: rtl/tlb_pid_victim.sv
module tlb_pid_victim #(
    parameter int N_ENTRIES = 64,
    parameter int RSV       = 8,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(RSV);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_ENTRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              victim <= FIRST;
        else if (victim == LAST) victim <= FIRST;
        else                     victim <= victim + 1'b1;
    end

    // R10: replacement never points into the reserved region
    assert_victim_unreserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        victim >= FIRST);
endmodule

// File: rtl/tlb_pid_xlate.sv
module tlb_pid_xlate
    import tlb_pid_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PFN_W     = 20,
    parameter int PID_W     = 6,
    parameter int N_ENTRIES = 64,
    parameter int RSV       = 8,
    parameter int VPN_W     = VA_W - OFF_W,
    parameter int PA_W      = PFN_W + OFF_W,
    parameter int RSV_W     = (RSV > 1) ? $clog2(RSV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] cur_pid,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    input  logic             fill_valid,
    input  logic             fill_system,
    input  logic [RSV_W-1:0] fill_slot,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_pte_valid,
    input  logic             fill_writable,
    input  logic             fill_dirty,
    input  logic             flush_all,
    input  logic             inv_pid_valid,
    input  logic [PID_W-1:0] inv_pid,
    output logic             dirty_upd_valid,
    output logic [VPN_W-1:0] dirty_upd_vpn,
    output logic [PID_W-1:0] dirty_upd_pid
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [VPN_W-1:0]     lk_vpn;
    logic [N_ENTRIES-1:0] lk_match, fl_match;
    logic [PFN_W-1:0]     lk_pfn;
    pte_flags_t           lk_flags, fill_flags;
    logic [IDX_W-1:0]     lk_idx, fl_idx, victim, fill_idx;
    logic                 lk_any, fl_any, dset_we;
    outcome_e             state_q, state_d;
    logic [PA_W-1:0]      paddr_q;
    logic                 dup_q;
    logic [VPN_W-1:0]     dup_vpn_q;
    logic [PID_W-1:0]     dup_pid_q;

    assign lk_vpn     = lk_vaddr[VA_W-1:OFF_W];
    assign fill_flags = '{pte_ok: fill_pte_valid, wr_ok: fill_writable, dirty: fill_dirty};

    tlb_pid_entries #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W),
                      .IDX_W(IDX_W)) u_entries (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_pid(cur_pid), .lk_match(lk_match),
        .lk_pfn(lk_pfn), .lk_flags(lk_flags),
        .fl_vpn(fill_vpn), .fl_pid(fill_pid), .fl_match(fl_match),
        .fill_we(fill_valid), .fill_idx(fill_idx), .fill_pfn(fill_pfn), .fill_flags(fill_flags),
        .dset_we(dset_we), .dset_idx(lk_idx),
        .flush_all(flush_all), .inv_en(inv_pid_valid), .inv_pid(inv_pid)
    );

    tlb_pid_enc #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
        .vec(lk_match), .idx(lk_idx), .any(lk_any));
    tlb_pid_enc #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_fl_enc (
        .vec(fl_match), .idx(fl_idx), .any(fl_any));
    tlb_pid_victim #(.N_ENTRIES(N_ENTRIES), .RSV(RSV), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .victim(victim));

    // slot choice: existing tag, then reserved slot, then replacement counter
    always_comb begin
        if (fl_any)           fill_idx = fl_idx;
        else if (fill_system) fill_idx = IDX_W'(fill_slot);
        else                  fill_idx = victim;
    end

    // next outcome
    always_comb begin
        if (!lk_valid)                        state_d = OUT_IDLE;
        else if (!lk_any)                     state_d = OUT_MISS;
        else if (!lk_flags.pte_ok)            state_d = OUT_PFAULT;
        else if (lk_write && !lk_flags.wr_ok) state_d = OUT_PROT;
        else                                  state_d = OUT_HIT;
    end

    assign dset_we = (state_d == OUT_HIT) && lk_write && !lk_flags.dirty;

    // state register and response payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= OUT_IDLE;
            paddr_q   <= '0;
            dup_q     <= 1'b0;
            dup_vpn_q <= '0;
            dup_pid_q <= '0;
        end else begin
            state_q   <= state_d;
            paddr_q   <= (state_d == OUT_HIT) ? {lk_pfn, lk_vaddr[OFF_W-1:0]} : '0;
            dup_q     <= dset_we;
            dup_vpn_q <= dset_we ? lk_vpn : '0;
            dup_pid_q <= dset_we ? cur_pid : '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_valid      = 1'b1;
        rsp_hit        = 1'b0;
        rsp_miss       = 1'b0;
        rsp_page_fault = 1'b0;
        rsp_prot_fault = 1'b0;
        rsp_paddr      = '0;
        unique case (state_q)
            OUT_IDLE:   rsp_valid      = 1'b0;
            OUT_HIT:    begin rsp_hit = 1'b1; rsp_paddr = paddr_q; end
            OUT_MISS:   rsp_miss       = 1'b1;
            OUT_PFAULT: rsp_page_fault = 1'b1;
            OUT_PROT:   rsp_prot_fault = 1'b1;
            default:    rsp_valid      = 1'b0;
        endcase
        dirty_upd_valid = dup_q;
        dirty_upd_vpn   = dup_vpn_q;
        dirty_upd_pid   = dup_pid_q;
    end

    // R2: one outcome per response, and only when a response is due
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault}) == (rsp_valid ? 1 : 0));
    // R2: a response follows a lookup by exactly one cycle
    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R4: no physical address leaks out without a hit
    assert_paddr_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0));
    // R5: a protection fault never marks the page dirty
    assert_prot_no_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> !dirty_upd_valid);
    // R6: a dirty update comes only from a write hit
    assert_dirty_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_upd_valid |-> (rsp_hit && $past(lk_valid && lk_write)));
endmodule

// File: tb/tlb_pid_xlate_tb.sv
`timescale 1ns/1ps
module tlb_pid_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  cur_pid = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr;
    logic        fill_valid = 0, fill_system = 0;
    logic [2:0]  fill_slot = '0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [5:0]  fill_pid = '0;
    logic        fill_pte_valid = 0, fill_writable = 0, fill_dirty = 0;
    logic        flush_all = 0, inv_pid_valid = 0;
    logic [5:0]  inv_pid = '0;
    logic        dirty_upd_valid;
    logic [19:0] dirty_upd_vpn;
    logic [5:0]  dirty_upd_pid;

    always #4 clk = ~clk;

    tlb_pid_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .cur_pid(cur_pid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_system(fill_system),
        .fill_slot(fill_slot), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
        .fill_pte_valid(fill_pte_valid), .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .inv_pid_valid(inv_pid_valid), .inv_pid(inv_pid),
        .dirty_upd_valid(dirty_upd_valid), .dirty_upd_vpn(dirty_upd_vpn),
        .dirty_upd_pid(dirty_upd_pid)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected outcome packed as {hit, miss, pfault, prot}
    logic [3:0]  exp_out_q [$];
    logic [31:0] exp_pa_q  [$];
    logic [26:0] exp_dup_q [$];   // {valid, vpn, pid}
    string       exp_tag_q [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] va, input logic [5:0] pid, input logic wr,
                         input logic [3:0] eo, input logic [31:0] epa, input logic edup,
                         input string tag);
        lk_valid = 1; lk_write = wr; lk_vaddr = va; cur_pid = pid;
        exp_out_q.push_back(eo);
        exp_pa_q.push_back(epa);
        exp_dup_q.push_back(edup ? {1'b1, va[31:12], pid} : 27'd0);
        exp_tag_q.push_back(tag);
    endtask

    task automatic lookup(input logic [31:0] va, input logic [5:0] pid, input logic wr,
                          input logic [3:0] eo, input logic [31:0] epa, input logic edup,
                          input string tag);
        @(negedge clk);
        issue(va, pid, wr, eo, epa, edup, tag);
        @(negedge clk);
        lk_valid = 0; lk_write = 0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [5:0] pid, input logic [19:0] pfn,
                          input logic ok, input logic wr, input logic sys, input logic [2:0] slot);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
        fill_pte_valid = ok; fill_writable = wr; fill_dirty = 0;
        fill_system = sys; fill_slot = slot;
        @(negedge clk);
        fill_valid = 0; fill_system = 0;
    endtask

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (exp_out_q.size() == 0) begin
                    check(0, "R2", "unexpected response", 64'(rsp_valid), 64'd0);
                end else begin
                    logic [3:0]  eo;
                    logic [31:0] epa;
                    logic [26:0] ed;
                    string       t;
                    eo = exp_out_q.pop_front(); epa = exp_pa_q.pop_front();
                    ed = exp_dup_q.pop_front(); t = exp_tag_q.pop_front();
                    check({rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault} == eo, t, "outcome",
                          64'({rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault}), 64'(eo));
                    check(rsp_paddr == epa, t, "paddr", 64'(rsp_paddr), 64'(epa));
                    check({dirty_upd_valid, dirty_upd_vpn, dirty_upd_pid} == ed, t, "dirty update",
                          64'({dirty_upd_valid, dirty_upd_vpn, dirty_upd_pid}), 64'(ed));
                end
            end else if (dirty_upd_valid) begin
                check(0, "R6", "dirty update without response", 64'd1, 64'd0);
            end
        end
    end

    localparam logic [3:0] HIT = 4'b1000, MISS = 4'b0100, PF = 4'b0010, PR = 4'b0001;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(dirty_upd_valid == 0, "R1", "dirty_upd after reset", 64'(dirty_upd_valid), 64'd0);
        lookup(32'h12345678, 6'd3, 0, MISS, 0, 0, "R1");

        // R2: basic hit, frame plus offset
        refill(20'h12345, 6'd3, 20'hABCDE, 1, 1, 0, 0);
        lookup(32'h12345678, 6'd3, 0, HIT, 32'hABCDE678, 0, "R2");
        lookup(32'h12345FFF, 6'd3, 0, HIT, 32'hABCDEFFF, 0, "R2");
        // R3: other process misses
        lookup(32'h12345678, 6'd4, 0, MISS, 0, 0, "R3");
        // R4: invalid entry gives page fault on tag hit
        refill(20'h00100, 6'd3, 20'h55555, 0, 1, 0, 0);
        lookup(32'h00100010, 6'd3, 0, PF, 0, 0, "R4");
        // R5: write-protected page
        refill(20'h00200, 6'd3, 20'h22222, 1, 0, 0, 0);
        lookup(32'h00200ABC, 6'd3, 0, HIT, 32'h22222ABC, 0, "R5");
        lookup(32'h00200ABC, 6'd3, 1, PR, 0, 0, "R5");
        // R6: first write sets dirty, second does not
        lookup(32'h12345004, 6'd3, 1, HIT, 32'hABCDE004, 1, "R6");
        lookup(32'h12345008, 6'd3, 1, HIT, 32'hABCDE008, 0, "R6");
        // R9: same tag refill overwrites, dirty comes from refill
        refill(20'h12345, 6'd3, 20'h11111, 1, 1, 0, 0);
        lookup(32'h12345678, 6'd3, 1, HIT, 32'h11111678, 1, "R9");
        // R8: invalidate one process only
        refill(20'h00300, 6'd5, 20'h33333, 1, 1, 0, 0);
        @(negedge clk); inv_pid_valid = 1; inv_pid = 6'd3;
        @(negedge clk); inv_pid_valid = 0;
        lookup(32'h12345678, 6'd3, 0, MISS, 0, 0, "R8");
        lookup(32'h00300001, 6'd5, 0, HIT, 32'h33333001, 0, "R8");
        // R10: reserved slot survives many ordinary refills
        refill(20'h00777, 6'd0, 20'h77777, 1, 1, 1, 3'd2);
        for (int k = 0; k < 70; k++)
            refill(20'h01000 + 20'(k), 6'd7, 20'(k), 1, 1, 0, 0);
        lookup(32'h00777123, 6'd0, 0, HIT, 32'h77777123, 0, "R10");
        lookup(32'h01045040, 6'd7, 0, HIT, 32'h00045040, 0, "R10");
        // R11: write hit and invalidation of its process in one cycle
        refill(20'h00400, 6'd9, 20'h44444, 1, 1, 0, 0);
        @(negedge clk);
        issue(32'h00400010, 6'd9, 1, HIT, 32'h44444010, 1, "R11");
        inv_pid_valid = 1; inv_pid = 6'd9;
        @(negedge clk);
        lk_valid = 0; lk_write = 0; inv_pid_valid = 0;
        lookup(32'h00400010, 6'd9, 0, MISS, 0, 0, "R11");
        // R11: lookup and refill of the same page in one cycle
        @(negedge clk);
        issue(32'h00500020, 6'd7, 0, MISS, 0, 0, "R11");
        fill_valid = 1; fill_vpn = 20'h00500; fill_pid = 6'd7; fill_pfn = 20'h50505;
        fill_pte_valid = 1; fill_writable = 1; fill_dirty = 0; fill_system = 0;
        @(negedge clk);
        lk_valid = 0; fill_valid = 0;
        lookup(32'h00500020, 6'd7, 0, HIT, 32'h50505020, 0, "R11");
        // R7: flush removes reserved and ordinary slots
        @(negedge clk); flush_all = 1;
        @(negedge clk); flush_all = 0;
        lookup(32'h00777123, 6'd0, 0, MISS, 0, 0, "R7");
        lookup(32'h00500020, 6'd7, 0, MISS, 0, 0, "R7");

        @(negedge clk);
        check(exp_out_q.size() == 0, "R2", "responses outstanding",
              64'(exp_out_q.size()), 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule